// File: doc/BRIEF.md
# Address-Command SPI Slave Framer

This block is an SPI slave in mode 3 (clock idles high, the slave samples MOSI on the rising edge and changes MISO on the falling edge), most significant bit first. Each frame opens with a header in which a memory address and a 3-bit command share the leading bytes. After the header, data bytes move between the SPI master and a byte-wide internal memory. The memory is reached through a request/acknowledge port.

A short header has two bytes. It reaches only the lowest 8 KB, because address bits [15:13] are taken as zero. When the first command field holds the extension code, a third header byte supplies the top three address bits and a second command field, and that second command is the one carried out. The address steps up by one after every data byte for as long as chip select stays low. One read variant places a single dummy byte between the header and the data, which gives a slow memory a full byte time to answer. All SPI inputs are oversampled in the system clock domain through a synchroniser.

Top module: `spi_ac_framer`

## Requirements
- R1: After reset, and whenever chip select has been high for a few clocks, `spi_miso` is 0 and no memory request starts.
- R2: With a short header, byte 0 gives address bits [12:5], the top five bits of byte 1 give bits [4:0], bits [15:13] are 0, and the low three bits of byte 1 are the command. Command 010 (read) returns memory data MSB first, starting with byte 2.
- R3: Every further data byte in a frame uses the previous address plus one. This holds for reads and writes, and carries across the 8 KB boundary.
- R4: Command 100 (write) stores each complete data byte that follows the header at the current address.
- R5: Command 110 in byte 1 adds a third header byte. Its bits [7:5] are address bits [15:13] and its bits [4:2] are the executed command. Data then starts at byte 3.
- R6: Command 011 (wait-state read) returns 0x00 in the byte right after the header. Memory data starts on the byte after that.
- R7: Command 000 and the reserved codes 001, 101 and 111 issue no memory request, and MISO stays 0 for every later byte of the frame.
- R8: When chip select rises in the middle of a byte, the partial byte is dropped, and no write is made for it.
- R9: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` held steady until `mem_ack`. It falls on the cycle after the acknowledge.
- R10: While chip select is inactive, `spi_miso` is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI clock from the master, idles high |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master (registered) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle acknowledge of the pending request |

## Verification
The bench builds the block with its defaults: a 16-bit address and a two-stage synchroniser. It drives SPI at eight system clocks per half SCLK period. Its memory model acknowledges each request two cycles after it is raised. With these values, a plain read just fits the half SCLK period between the header's last rising edge and the first data falling edge, so the prefetch timing is exercised. The model records each write at its acknowledge, so a request that changed its address or data while waiting would show up as a wrong log entry. The 16-bit address lets the extended header reach addresses above 0xA000, and it lets a short-header write run across 0x1FFF into 0x2000.

// File: rtl/spi_ac_pkg.sv
package spi_ac_pkg;

  localparam int unsigned BYTE_W = 8;

  // 3-bit command codes carried in the header
  typedef enum logic [2:0] {
    CMD_NOP     = 3'b000,
    CMD_RSV1    = 3'b001,
    CMD_READ    = 3'b010,
    CMD_READ_WS = 3'b011,
    CMD_WRITE   = 3'b100,
    CMD_RSV5    = 3'b101,
    CMD_EXT     = 3'b110,
    CMD_RSV7    = 3'b111
  } ac_cmd_e;

  function automatic logic cmd_is_read(ac_cmd_e c);
    return (c == CMD_READ) || (c == CMD_READ_WS);
  endfunction

endpackage

// File: rtl/spi_ac_sync.sv
module spi_ac_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_ac_shift.sv
module spi_ac_shift
  import spi_ac_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              cs_act,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] load_val,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              load_evt,
  output logic              miso
);

  localparam int unsigned BIT_W = $clog2(BYTE_W);

  logic              sclk_d;
  logic [BIT_W-1:0]  bitcnt;
  logic [BYTE_W-2:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              rise, fall;

  assign rise     = cs_act &  sclk_s & ~sclk_d;
  assign fall     = cs_act & ~sclk_s &  sclk_d;
  // first falling edge of a byte: present a fresh transmit byte
  assign load_evt = fall && (bitcnt == '0);
  assign miso     = tx_sh[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b1;
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
    end else begin
      sclk_d    <= sclk_s;
      byte_done <= 1'b0;
      if (!cs_act) begin
        bitcnt <= '0;
        tx_sh  <= '0;
      end else begin
        if (rise) begin
          rx_sh  <= {rx_sh[BYTE_W-3:0], mosi_s};
          bitcnt <= bitcnt + BIT_W'(1);
          if (bitcnt == BIT_W'(BYTE_W-1)) begin
            byte_done <= 1'b1;
            rx_byte   <= {rx_sh, mosi_s};
          end
        end
        if (fall) begin
          if (load_evt) tx_sh <= load_val;
          else          tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/spi_ac_ctrl.sv
module spi_ac_ctrl
  import spi_ac_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              load_evt,
  output logic [BYTE_W-1:0] load_val,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  localparam int unsigned HI_W  = 3;
  localparam int unsigned LOW_W = ADDR_W - HI_W;
  localparam int unsigned B1_W  = 5;

  logic [1:0]        hdr_idx;
  logic              hdr_done;
  ac_cmd_e           exec_cmd;
  logic              data_phase;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] rd_buf;

  ac_cmd_e           cmd_b1, cmd_b2, fin_cmd;
  logic [ADDR_W-1:0] addr_b1, addr_b2, fin_addr, iss_addr;
  logic              hdr_fin, iss, iss_we;

  assign cmd_b1  = ac_cmd_e'(rx_byte[2:0]);
  assign cmd_b2  = ac_cmd_e'(rx_byte[4:2]);
  assign addr_b1 = {{HI_W{1'b0}}, addr_q[LOW_W-1:B1_W], rx_byte[BYTE_W-1:HI_W]};
  assign addr_b2 = {rx_byte[BYTE_W-1:BYTE_W-HI_W], addr_q[LOW_W-1:0]};

  // header completion
  always_comb begin
    hdr_fin  = 1'b0;
    fin_cmd  = CMD_NOP;
    fin_addr = addr_q;
    if (cs_act && byte_done && !hdr_done) begin
      if (hdr_idx == 2'd1 && cmd_b1 != CMD_EXT) begin
        hdr_fin  = 1'b1;
        fin_cmd  = cmd_b1;
        fin_addr = addr_b1;
      end else if (hdr_idx == 2'd2) begin
        hdr_fin  = 1'b1;
        fin_cmd  = cmd_b2;
        fin_addr = addr_b2;
      end
    end
  end

  // memory access issue: first read at header end, writes per byte, read prefetch per byte
  always_comb begin
    iss      = 1'b0;
    iss_we   = 1'b0;
    iss_addr = addr_q;
    if (hdr_fin && cmd_is_read(fin_cmd)) begin
      iss      = 1'b1;
      iss_addr = fin_addr;
    end else if (cs_act && byte_done && hdr_done && data_phase && exec_cmd == CMD_WRITE) begin
      iss    = 1'b1;
      iss_we = 1'b1;
    end else if (load_evt && data_phase && cmd_is_read(exec_cmd)) begin
      iss = 1'b1;
    end
  end

  assign load_val = (data_phase && cmd_is_read(exec_cmd)) ? rd_buf : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (iss) begin
      mem_req   <= 1'b1;
      mem_we    <= iss_we;
      mem_addr  <= iss_addr;
      mem_wdata <= rx_byte;
    end else if (mem_ack) begin
      mem_req   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_idx    <= '0;
      hdr_done   <= 1'b0;
      exec_cmd   <= CMD_NOP;
      data_phase <= 1'b0;
      addr_q     <= '0;
      rd_buf     <= '0;
    end else begin
      if (mem_req && mem_ack) begin
        addr_q <= addr_q + ADDR_W'(1);
        if (!mem_we) rd_buf <= mem_rdata;
      end
      if (!cs_act) begin
        hdr_idx    <= '0;
        hdr_done   <= 1'b0;
        exec_cmd   <= CMD_NOP;
        data_phase <= 1'b0;
      end else if (byte_done) begin
        if (!hdr_done) begin
          hdr_idx <= hdr_idx + 2'd1;
          if (hdr_idx == 2'd0) addr_q[LOW_W-1:B1_W] <= rx_byte;
          else if (!hdr_fin)   addr_q <= addr_b1;
        end
        if (hdr_fin) begin
          hdr_done   <= 1'b1;
          exec_cmd   <= fin_cmd;
          addr_q     <= fin_addr;
          data_phase <= (fin_cmd == CMD_READ) || (fin_cmd == CMD_WRITE);
        end else if (hdr_done && exec_cmd == CMD_READ_WS && !data_phase) begin
          data_phase <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_ac_framer.sv
module spi_ac_framer
  import spi_ac_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  localparam int unsigned PIN_W = 3;

  logic [PIN_W-1:0]  pins_s;
  logic              cs_act, byte_done, load_evt;
  logic [BYTE_W-1:0] rx_byte, load_val;

  spi_ac_sync #(
    .W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)
  ) i_sync (
    .clk(clk), .rst(rst),
    .d({spi_mosi, spi_cs_n, spi_sclk}),
    .q(pins_s)
  );

  assign cs_act = ~pins_s[1];

  spi_ac_shift i_shift (
    .clk(clk), .rst(rst),
    .sclk_s(pins_s[0]), .cs_act(cs_act), .mosi_s(pins_s[2]),
    .load_val(load_val), .byte_done(byte_done), .rx_byte(rx_byte),
    .load_evt(load_evt), .miso(spi_miso)
  );

  spi_ac_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rst(rst),
    .cs_act(cs_act), .byte_done(byte_done), .rx_byte(rx_byte),
    .load_evt(load_evt), .load_val(load_val),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

endmodule

// File: rtl/spi_ac_framer_chk.sv
module spi_ac_framer_chk #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              spi_cs_n,
  input logic              spi_miso,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              mem_ack
);

  localparam int unsigned IDLE_LAT = SYNC_STAGES + 3;
  localparam int unsigned CNT_W    = $clog2(IDLE_LAT + 2);

  logic [CNT_W-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst || !spi_cs_n)                      idle_cnt <= '0;
    else if (idle_cnt != CNT_W'(IDLE_LAT + 1)) idle_cnt <= idle_cnt + CNT_W'(1);
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9

  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> !mem_req); // R9

  AST_IDLE_MISO_LOW: assert property (@(posedge clk) disable iff (rst)
    (idle_cnt >= CNT_W'(IDLE_LAT)) |-> !spi_miso); // R10

  AST_IDLE_NO_NEW_REQ: assert property (@(posedge clk) disable iff (rst)
    (idle_cnt >= CNT_W'(IDLE_LAT)) |-> !$rose(mem_req)); // R1

endmodule

bind spi_ac_framer spi_ac_framer_chk #(
  .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/test_spi_ac_framer.sv
`timescale 1ns/1ps
module test_spi_ac_framer;

  localparam int HALF    = 8;   // system clocks per half SCLK period
  localparam int ACK_DLY = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
  logic        miso;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  int n_run = 0, n_fail = 0;
  int n_req = 0, n_wr = 0;
  logic        req_d;
  logic [1:0]  dly;
  logic [15:0] log_a [16];
  logic [7:0]  log_d [16];

  always #2 clk = ~clk;

  spi_ac_framer i_spi_ac_framer (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // memory model: acknowledge after a delay, log writes at the acknowledge
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0; dly <= '0; mem_rdata <= '0; req_d <= 1'b0;
    end else begin
      req_d   <= mem_req;
      if (mem_req && !req_d) n_req <= n_req + 1;
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (dly == 2'(ACK_DLY)) begin
          mem_ack   <= 1'b1;
          dly       <= '0;
          mem_rdata <= pat(mem_addr);
          if (mem_we) begin
            log_a[n_wr % 16] <= mem_addr;
            log_d[n_wr % 16] <= mem_wdata;
            n_wr <= n_wr + 1;
          end
        end else begin
          dly <= dly + 2'd1;
        end
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cs_on();
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4*HALF) @(negedge clk);
    check("R10 miso idle", 16'(miso), 16'h0);
  endtask

  task automatic send_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      @(negedge clk); sclk = 1'b0; mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF-1) @(negedge clk);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    send_bits(tx, 8, rx);
  endtask

  task automatic t_reset();
    check("R1 miso after reset", 16'(miso), 16'h0);
    check("R1 mem_req after reset", 16'(mem_req), 16'h0);
  endtask

  task automatic t_read_short();
    logic [7:0] r;
    cs_on();
    xfer(8'h09, r); xfer(8'h1A, r);           // addr 0x0123, cmd 010
    xfer(8'h00, r); check("R2 first read byte", 16'(r), 16'(pat(16'h0123)));
    xfer(8'h00, r); check("R3 read increment 1", 16'(r), 16'(pat(16'h0124)));
    xfer(8'h00, r); check("R3 read increment 2", 16'(r), 16'(pat(16'h0125)));
    cs_off();
  endtask

  task automatic t_write_short();
    logic [7:0] r; int base;
    base = n_wr;
    cs_on();
    xfer(8'hFF, r); xfer(8'hF4, r);           // addr 0x1FFE, cmd 100
    xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r);
    cs_off();
    check("R4 write count", 16'(n_wr - base), 16'd3);
    check("R4 R9 write0 addr", log_a[base % 16], 16'h1FFE);
    check("R4 R9 write0 data", 16'(log_d[base % 16]), 16'h11);
    check("R3 write1 addr", log_a[(base+1) % 16], 16'h1FFF);
    check("R3 write2 addr past 8KB", log_a[(base+2) % 16], 16'h2000);
    check("R9 write2 data", 16'(log_d[(base+2) % 16]), 16'h33);
  endtask

  task automatic t_read_ext();
    logic [7:0] r;
    cs_on();
    xfer(8'h07, r); xfer(8'h86, r); xfer(8'hE8, r);   // 0xE0F0, CMD1 read
    xfer(8'h00, r); check("R5 ext read byte3", 16'(r), 16'(pat(16'hE0F0)));
    xfer(8'h00, r); check("R5 ext read byte4", 16'(r), 16'(pat(16'hE0F1)));
    cs_off();
  endtask

  task automatic t_write_ext();
    logic [7:0] r; int base;
    base = n_wr;
    cs_on();
    xfer(8'h00, r); xfer(8'h2E, r); xfer(8'hB0, r);   // 0xA005, CMD1 write
    xfer(8'h3C, r); xfer(8'hC3, r);
    cs_off();
    check("R5 ext write count", 16'(n_wr - base), 16'd2);
    check("R5 ext write addr", log_a[base % 16], 16'hA005);
    check("R5 ext write data", 16'(log_d[base % 16]), 16'h3C);
    check("R5 ext write addr+1", log_a[(base+1) % 16], 16'hA006);
  endtask

  task automatic t_read_wait();
    logic [7:0] r;
    cs_on();
    xfer(8'h02, r); xfer(8'h03, r);           // addr 0x0040, cmd 011
    xfer(8'h00, r); check("R6 dummy byte", 16'(r), 16'h00);
    xfer(8'h00, r); check("R6 first data", 16'(r), 16'(pat(16'h0040)));
    xfer(8'h00, r); check("R6 second data", 16'(r), 16'(pat(16'h0041)));
    cs_off();
  endtask

  task automatic t_nop_reserved(input logic [7:0] b1, input string tag);
    logic [7:0] r; logic [7:0] acc; int base;
    base = n_req; acc = '0;
    cs_on();
    xfer(8'h12, r); xfer(b1, r);
    xfer(8'hFF, r); acc |= r;
    xfer(8'hA5, r); acc |= r;
    xfer(8'h5A, r); acc |= r;
    cs_off();
    check({"R7 miso zero ", tag}, 16'(acc), 16'h0);
    check({"R7 no request ", tag}, 16'(n_req - base), 16'd0);
  endtask

  task automatic t_partial();
    logic [7:0] r; int base;
    base = n_wr;
    cs_on();
    xfer(8'h00, r); xfer(8'h84, r);           // addr 0x0010, cmd 100
    xfer(8'h77, r);
    send_bits(8'hF0, 4, r);
    cs_off();
    check("R8 only full byte written", 16'(n_wr - base), 16'd1);
    check("R8 written addr", log_a[base % 16], 16'h0010);
    check("R8 written data", 16'(log_d[base % 16]), 16'h77);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    t_reset();
    t_read_short();
    t_write_short();
    t_read_ext();
    t_write_ext();
    t_read_wait();
    t_nop_reserved(8'h30, "nop");
    t_nop_reserved(8'h35, "rsv101");
    t_nop_reserved(8'h37, "rsv111");
    t_partial();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule